// File: doc/BRIEF.md
# Packed register operand field decoder

This block turns a compact instruction word into register indices, an immediate value and a valid flag. The encoding stores only the two low bits of each register operand in their own bit pairs. The high parts of two or three operands share one 5-bit field at bits 10 to 6 of a 16-bit half-word. That field holds them as base-3 digits, which gives twelve registers (indices 0 to 11) from fewer bits than a plain binary field would need. The block also expands a 4-bit bit-position code into a shift amount through a fixed table. It handles four-register and six-register long forms, which use the upper half of a 32-bit word.

Opcode selection has already happened upstream. The caller presents the instruction word (the 16-bit form in bits 15 to 0), a long-word flag and an operand-form code. One clock later the block returns the decoded operands in numbered slots. When the field pattern cannot occur for the chosen form, the valid flag is low. The register file and the assembly of words from bytes are outside this block.

Top module: `pkd_operand_decode`

## Requirements
- R1: Outputs are registered. A synchronous active-high reset clears valid, all index slots and the immediate to zero. Otherwise the result for the inputs present at a rising edge appears at the outputs after that edge.
- R2: Triple form (form code 1): let c = bits 10..6. If c < 27, slot 0 = {c mod 3, bits 5..4}, slot 1 = {(c/3) mod 3, bits 3..2} and slot 2 = {c/9, bits 1..0}, and valid is high.
- R3: Triple form with c of 27 or more gives valid low.
- R4: Pair form (form code 0): with c of 27 or more, let a = c - 27, plus 5 when bit 5 is set. Then slot 0 = {a mod 3, bits 3..2}, slot 1 = {a/3, bits 1..0}, and valid is high.
- R5: Pair form is rejected (valid low) when c < 27, or when bit 5 is set and c = 31. With bit 5 clear, c = 31 is accepted.
- R6: Register-plus-immediate form (form code 2) uses the pair decode. Slot 0 holds the first operand and the immediate output holds the second operand's value.
- R7: Register-plus-bit-position form (form code 3) uses the pair decode. Slot 0 holds the first operand. The second operand's value k maps to the immediate: k = 0 gives 32, k = 1..8 gives k, 9 gives 16, 10 gives 24 and 11 gives 32. Codes above 11 are invalid.
- R8: Four-register form (form code 4): the triple decode of bits 15..0 fills slots 0 to 2, and slot 3 is bits 19..16 taken directly. A value of 12 or more in bits 19..16 gives valid low.
- R9: Six-register form (form code 5): triple decodes of bits 15..0 and of bits 31..16 fill slots 0 to 2 and slots 3 to 5. The word is valid only if both halves decode.
- R10: Forms 4 and 5 require the long flag. With the long flag low they give valid low, and form codes 6 and 7 always give valid low.
- R11: When valid is low, every slot and the immediate are zero. When valid is high, slots and immediate bits not used by the form are zero.
- R12: For forms 0 to 3, bits 31..16 and the long flag have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word; a 16-bit form sits in bits 15..0 |
| is_long_i | input | 1 | High when the word is a 32-bit instruction |
| form_i | input | 3 | Operand form code (0 pair, 1 triple, 2 reg+imm, 3 reg+bitpos, 4 quad long, 5 hex long) |
| reg_idx_o | output | 24 | Six 4-bit register index slots; slot k in bits 4k+3..4k |
| imm_o | output | 6 | Decoded immediate value |
| valid_o | output | 1 | High when the word decodes for the selected form |

## Verification
The properties assume that the inputs are stable and defined at every rising edge after reset, because each result is compared with the inputs one cycle earlier. The bench changes inputs only on falling edges and starts from a defined word during reset. Stimulus is built by encoding chosen register numbers into the packed field. Rejected patterns are placed at the exact boundaries: 26 and 27, and 31 with and without bit 5.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

    localparam int REG_W       = 4;    // register index width
    localparam int LOW_W       = 2;    // low bits stored per operand
    localparam int HALF_W      = 16;   // one instruction half-word
    localparam int GROUP_W     = 11;   // bits of a half-word used by a triple group
    localparam int FIELD_LSB   = 6;    // position of the shared digit field
    localparam int FIELD_W     = 5;
    localparam int SEL_BIT     = 5;    // pair-form adjust bit
    localparam int NUM_SLOTS   = 6;
    localparam int NUM_HALVES  = 2;
    localparam int IMM_W       = 6;
    localparam int REG_LIMIT   = 12;
    localparam int TRIPLE_SPAN = 27;   // 3*3*3 digit combinations
    localparam int PAIR_BASE   = 27;
    localparam int PAIR_SHIFT  = 5;
    localparam int QUAD_LSB    = 16;

    typedef enum logic [2:0] {
        FORM_PAIR       = 3'd0,
        FORM_TRIPLE     = 3'd1,
        FORM_REG_IMM    = 3'd2,
        FORM_REG_BITPOS = 3'd3,
        FORM_QUAD_LONG  = 3'd4,
        FORM_HEX_LONG   = 3'd5
    } form_e;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef struct packed {
        logic     ok;
        reg_idx_t a;
        reg_idx_t b;
    } pair_t;

    typedef struct packed {
        logic     ok;
        reg_idx_t a;
        reg_idx_t b;
        reg_idx_t c;
    } triple_t;

    typedef struct packed {
        logic              ok;
        logic [IMM_W-1:0]  value;
    } bitpos_t;

endpackage

// File: rtl/pkd_triple_dec.sv
module pkd_triple_dec
    import pkd_pkg::*;
(
    input  logic [GROUP_W-1:0] grp_i,
    output triple_t            dec_o
);
    logic [FIELD_W-1:0] digits;
    logic [FIELD_W-1:0] d_first, d_second, d_third;

    always_comb begin
        digits   = grp_i[FIELD_LSB +: FIELD_W];
        d_first  = digits % FIELD_W'(3);
        d_second = (digits / FIELD_W'(3)) % FIELD_W'(3);
        d_third  = digits / FIELD_W'(9);
        dec_o.ok = digits < FIELD_W'(TRIPLE_SPAN);
        dec_o.a  = {d_first[LOW_W-1:0],  grp_i[4 +: LOW_W]};
        dec_o.b  = {d_second[LOW_W-1:0], grp_i[2 +: LOW_W]};
        dec_o.c  = {d_third[LOW_W-1:0],  grp_i[0 +: LOW_W]};
    end
endmodule

// File: rtl/pkd_pair_dec.sv
module pkd_pair_dec
    import pkd_pkg::*;
(
    input  logic [FIELD_W-1:0] digits_i,
    input  logic               adjust_i,
    input  logic [3:0]         lows_i,
    output pair_t              dec_o
);
    localparam int SUM_W = FIELD_W + 1;

    logic [SUM_W-1:0] shifted;
    logic [SUM_W-1:0] h_first, h_second;

    always_comb begin
        shifted  = {1'b0, digits_i} + (adjust_i ? SUM_W'(PAIR_SHIFT) : '0)
                   - SUM_W'(PAIR_BASE);
        h_first  = shifted % SUM_W'(3);
        h_second = shifted / SUM_W'(3);
        dec_o.ok = (digits_i >= FIELD_W'(PAIR_BASE)) &&
                   !(adjust_i && (digits_i == '1));
        dec_o.a  = {h_first[LOW_W-1:0],  lows_i[2 +: LOW_W]};
        dec_o.b  = {h_second[LOW_W-1:0], lows_i[0 +: LOW_W]};
    end
endmodule

// File: rtl/pkd_bitpos_lut.sv
module pkd_bitpos_lut
    import pkd_pkg::*;
(
    input  reg_idx_t code_i,
    output bitpos_t  res_o
);
    always_comb begin
        res_o.ok = code_i < REG_W'(REG_LIMIT);
        if (code_i == '0 || code_i == REG_W'(11))
            res_o.value = IMM_W'(32);
        else if (code_i <= REG_W'(8))
            res_o.value = IMM_W'(code_i);
        else if (code_i == REG_W'(9))
            res_o.value = IMM_W'(16);
        else if (code_i == REG_W'(10))
            res_o.value = IMM_W'(24);
        else
            res_o.value = '0;
        if (!res_o.ok)
            res_o.value = '0;
    end
endmodule

// File: rtl/pkd_operand_decode.sv
module pkd_operand_decode
    import pkd_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2*HALF_W-1:0]        insn_i,
    input  logic                       is_long_i,
    input  logic [2:0]                 form_i,
    output logic [NUM_SLOTS*REG_W-1:0] reg_idx_o,
    output logic [IMM_W-1:0]           imm_o,
    output logic                       valid_o
);
    triple_t tri_dec [NUM_HALVES];
    pair_t   pair_dec;
    bitpos_t bp_dec;

    logic [NUM_SLOTS-1:0][REG_W-1:0] slots_d, slots_q;
    logic [IMM_W-1:0]                imm_d, imm_q;
    logic                            ok_d, ok_q;
    form_e                           form;
    reg_idx_t                        quad_reg;

    logic unused_bits;
    assign unused_bits = ^{insn_i[31:27], insn_i[15:11], insn_i[4]};

    // One triple decoder per half-word; the upper one serves long forms.
    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        pkd_triple_dec u_triple (
            .grp_i (insn_i[g*HALF_W +: GROUP_W]),
            .dec_o (tri_dec[g])
        );
    end

    pkd_pair_dec u_pair (
        .digits_i (insn_i[FIELD_LSB +: FIELD_W]),
        .adjust_i (insn_i[SEL_BIT]),
        .lows_i   (insn_i[3:0]),
        .dec_o    (pair_dec)
    );

    pkd_bitpos_lut u_bitpos (
        .code_i (pair_dec.b),
        .res_o  (bp_dec)
    );

    assign quad_reg = insn_i[QUAD_LSB +: REG_W];

    always_comb begin
        form    = form_e'(form_i);
        slots_d = '0;
        imm_d   = '0;
        ok_d    = 1'b0;
        unique case (form)
            FORM_PAIR: begin
                ok_d       = pair_dec.ok;
                slots_d[0] = pair_dec.a;
                slots_d[1] = pair_dec.b;
            end
            FORM_TRIPLE: begin
                ok_d       = tri_dec[0].ok;
                slots_d[0] = tri_dec[0].a;
                slots_d[1] = tri_dec[0].b;
                slots_d[2] = tri_dec[0].c;
            end
            FORM_REG_IMM: begin
                ok_d       = pair_dec.ok;
                slots_d[0] = pair_dec.a;
                imm_d      = IMM_W'(pair_dec.b);
            end
            FORM_REG_BITPOS: begin
                ok_d       = pair_dec.ok && bp_dec.ok;
                slots_d[0] = pair_dec.a;
                imm_d      = bp_dec.value;
            end
            FORM_QUAD_LONG: begin
                ok_d       = is_long_i && tri_dec[0].ok &&
                             (quad_reg < REG_W'(REG_LIMIT));
                slots_d[0] = tri_dec[0].a;
                slots_d[1] = tri_dec[0].b;
                slots_d[2] = tri_dec[0].c;
                slots_d[3] = quad_reg;
            end
            FORM_HEX_LONG: begin
                ok_d       = is_long_i && tri_dec[0].ok && tri_dec[1].ok;
                slots_d[0] = tri_dec[0].a;
                slots_d[1] = tri_dec[0].b;
                slots_d[2] = tri_dec[0].c;
                slots_d[3] = tri_dec[1].a;
                slots_d[4] = tri_dec[1].b;
                slots_d[5] = tri_dec[1].c;
            end
            default: ok_d = 1'b0;
        endcase
        // A rejected word leaves nothing stale on the outputs.
        if (!ok_d) begin
            slots_d = '0;
            imm_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            imm_q   <= '0;
            ok_q    <= 1'b0;
        end else begin
            slots_q <= slots_d;
            imm_q   <= imm_d;
            ok_q    <= ok_d;
        end
    end

    assign reg_idx_o = slots_q;
    assign imm_o     = imm_q;
    assign valid_o   = ok_q;

endmodule

// File: rtl/pkd_operand_decode_chk.sv
module pkd_operand_decode_chk
    import pkd_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [2*HALF_W-1:0]        insn_i,
    input logic                       is_long_i,
    input logic [2:0]                 form_i,
    input logic [NUM_SLOTS*REG_W-1:0] reg_idx_o,
    input logic [IMM_W-1:0]           imm_o,
    input logic                       valid_o
);
    logic [FIELD_W-1:0] digits;
    assign digits = insn_i[FIELD_LSB +: FIELD_W];

    p_triple_range_r3: assert property (@(posedge clk) disable iff (rst)
        (form_i == FORM_TRIPLE && digits >= FIELD_W'(TRIPLE_SPAN)) |=> !valid_o);

    p_pair_reject_r5: assert property (@(posedge clk) disable iff (rst)
        (form_i == FORM_PAIR &&
         (digits < FIELD_W'(PAIR_BASE) || (insn_i[SEL_BIT] && digits == '1)))
        |=> !valid_o);

    p_bitpos_set_r7: assert property (@(posedge clk) disable iff (rst)
        (form_i == FORM_REG_BITPOS) |=>
        (!valid_o || (imm_o != '0 && (imm_o <= IMM_W'(8) || imm_o == IMM_W'(16) ||
                                      imm_o == IMM_W'(24) || imm_o == IMM_W'(32)))));

    p_quad_limit_r8: assert property (@(posedge clk) disable iff (rst)
        (form_i == FORM_QUAD_LONG && insn_i[QUAD_LSB +: REG_W] >= REG_W'(REG_LIMIT))
        |=> !valid_o);

    p_long_only_r10: assert property (@(posedge clk) disable iff (rst)
        (!is_long_i && form_i >= FORM_QUAD_LONG) |=> !valid_o);

    p_quiet_invalid_r11: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (reg_idx_o == '0 && imm_o == '0));

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        p_index_range_r2: assert property (@(posedge clk) disable iff (rst)
            valid_o |-> (reg_idx_o[k*REG_W +: REG_W] < REG_W'(REG_LIMIT)));
    end

endmodule

bind pkd_operand_decode pkd_operand_decode_chk i_chk (.*);

// File: tb/test_pkd_operand_decode.sv
module test_pkd_operand_decode;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn = 32'h0;
    logic        is_long = 1'b0;
    logic [2:0]  form = 3'd0;
    logic [23:0] reg_idx;
    logic [5:0]  imm;
    logic        valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pkd_operand_decode i_pkd_operand_decode (
        .clk       (clk),
        .rst       (rst),
        .insn_i    (insn),
        .is_long_i (is_long),
        .form_i    (form),
        .reg_idx_o (reg_idx),
        .imm_o     (imm),
        .valid_o   (valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge (one register).
    task automatic apply(input logic [31:0] w, input logic lg, input logic [2:0] f);
        @(negedge clk);
        insn = w; is_long = lg; form = f;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic v,
                              input logic [23:0] idx, input logic [5:0] im);
        check({tag, " valid"}, 32'(valid), 32'(v));
        check({tag, " idx"},   32'(reg_idx), 32'(idx));
        check({tag, " imm"},   32'(imm), 32'(im));
    endtask

    function automatic logic [23:0] pack6(input logic [3:0] s0, s1, s2, s3, s4, s5);
        return {s5, s4, s3, s2, s1, s0};
    endfunction

    function automatic logic [15:0] enc3(input logic [3:0] x, y, z);
        int c;
        c = int'(x[3:2]) + 3 * int'(y[3:2]) + 9 * int'(z[3:2]);
        return {5'b0, 5'(c), x[1:0], y[1:0], z[1:0]};
    endfunction

    function automatic logic [15:0] enc2(input logic [3:0] x, y);
        int a, c;
        logic b5;
        a = int'(x[3:2]) + 3 * int'(y[3:2]);
        if (a <= 4) begin c = a + 27; b5 = 1'b0; end
        else        begin c = a + 22; b5 = 1'b1; end
        return {5'b0, 5'(c), b5, 1'b0, x[1:0], y[1:0]};
    endfunction

    function automatic logic [5:0] bitpos_ref(input int k);
        case (k)
            0, 11:   return 6'd32;
            9:       return 6'd16;
            10:      return 6'd24;
            default: return 6'(k);
        endcase
    endfunction

    task automatic t_reset_r1;
        @(negedge clk);
        rst = 1'b1; insn = {16'h0, enc3(4'd5, 4'd6, 4'd7)}; form = 3'd1;
        @(negedge clk);
        expect_out("R1 reset", 1'b0, 24'h0, 6'h0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1 first result", 1'b1, pack6(5, 6, 7, 0, 0, 0), 6'h0);
    endtask

    task automatic t_triple_r2;
        logic [3:0] v [4][3] = '{'{0, 0, 0}, '{11, 11, 11}, '{5, 7, 2}, '{3, 10, 8}};
        for (int i = 0; i < 4; i++) begin
            apply({16'h0, enc3(v[i][0], v[i][1], v[i][2])}, 1'b0, 3'd1);
            expect_out("R2 triple", 1'b1, pack6(v[i][0], v[i][1], v[i][2], 0, 0, 0), 6'h0);
        end
    endtask

    task automatic t_triple_bad_r3;
        apply(32'h0000_06C0 | 32'h3F, 1'b0, 3'd1);          // digits = 27
        expect_out("R3 digits 27 R11", 1'b0, 24'h0, 6'h0);
        apply(32'h0000_07FF, 1'b0, 3'd1);                    // digits = 31
        expect_out("R3 digits 31", 1'b0, 24'h0, 6'h0);
        apply(32'h0000_0680, 1'b0, 3'd1);                    // digits = 26
        expect_out("R3 digits 26 ok", 1'b1, pack6(4'd8, 4'd8, 4'd8, 0, 0, 0), 6'h0);
    endtask

    task automatic t_pair_r4;
        for (int h1 = 0; h1 < 3; h1++)
            for (int h2 = 0; h2 < 3; h2++) begin
                logic [3:0] x, y;
                x = 4'(h1 * 4 + ((h1 + h2) % 4));
                y = 4'(h2 * 4 + (3 - h1));
                apply({16'h0, enc2(x, y)}, 1'b0, 3'd0);
                expect_out("R4 pair", 1'b1, pack6(x, y, 0, 0, 0, 0), 6'h0);
            end
    endtask

    task automatic t_pair_bad_r5;
        apply(32'h0000_0680, 1'b0, 3'd0);                    // digits 26
        expect_out("R5 digits 26", 1'b0, 24'h0, 6'h0);
        apply(32'h0000_000F, 1'b0, 3'd0);                    // digits 0
        expect_out("R5 digits 0", 1'b0, 24'h0, 6'h0);
        apply(32'h0000_07E5, 1'b0, 3'd0);                    // digits 31, bit5 set
        expect_out("R5 digits 31 adjust", 1'b0, 24'h0, 6'h0);
        apply(32'h0000_07C9, 1'b0, 3'd0);                    // digits 31, bit5 clear: a=4
        expect_out("R5 digits 31 plain", 1'b1, pack6(4'd6, 4'd5, 0, 0, 0, 0), 6'h0);
    endtask

    task automatic t_reg_imm_r6;
        apply({16'h0, enc2(4'd9, 4'd7)}, 1'b0, 3'd2);
        expect_out("R6 reg imm R11", 1'b1, pack6(4'd9, 0, 0, 0, 0, 0), 6'd7);
        apply({16'h0, enc2(4'd2, 4'd11)}, 1'b0, 3'd2);
        expect_out("R6 reg imm max", 1'b1, pack6(4'd2, 0, 0, 0, 0, 0), 6'd11);
    endtask

    task automatic t_bitpos_r7;
        for (int k = 0; k < 12; k++) begin
            apply({16'h0, enc2(4'd3, 4'(k))}, 1'b0, 3'd3);
            expect_out($sformatf("R7 bitpos code %0d", k), 1'b1,
                       pack6(4'd3, 0, 0, 0, 0, 0), bitpos_ref(k));
        end
    endtask

    task automatic t_quad_r8;
        apply({12'hABC, 4'd11, enc3(4'd1, 4'd4, 4'd9)}, 1'b1, 3'd4);
        expect_out("R8 quad", 1'b1, pack6(4'd1, 4'd4, 4'd9, 4'd11, 0, 0), 6'h0);
        apply({12'h0, 4'd12, enc3(4'd1, 4'd4, 4'd9)}, 1'b1, 3'd4);
        expect_out("R8 quad reg 12", 1'b0, 24'h0, 6'h0);
        apply({12'h0, 4'd3, 16'h07C0}, 1'b1, 3'd4);
        expect_out("R8 quad bad group", 1'b0, 24'h0, 6'h0);
    endtask

    task automatic t_hex_r9;
        apply({enc3(4'd10, 4'd0, 4'd6), enc3(4'd7, 4'd11, 4'd3)}, 1'b1, 3'd5);
        expect_out("R9 hex", 1'b1, pack6(4'd7, 4'd11, 4'd3, 4'd10, 4'd0, 4'd6), 6'h0);
        apply({16'h06C0, enc3(4'd7, 4'd11, 4'd3)}, 1'b1, 3'd5);
        expect_out("R9 hex upper bad", 1'b0, 24'h0, 6'h0);
        apply({enc3(4'd1, 4'd2, 4'd3), 16'h07FF}, 1'b1, 3'd5);
        expect_out("R9 hex lower bad", 1'b0, 24'h0, 6'h0);
    endtask

    task automatic t_forms_r10;
        apply({enc3(4'd1, 4'd2, 4'd3), enc3(4'd4, 4'd5, 4'd6)}, 1'b0, 3'd5);
        expect_out("R10 hex short", 1'b0, 24'h0, 6'h0);
        apply({12'h0, 4'd2, enc3(4'd4, 4'd5, 4'd6)}, 1'b0, 3'd4);
        expect_out("R10 quad short", 1'b0, 24'h0, 6'h0);
        apply({16'h0, enc3(4'd4, 4'd5, 4'd6)}, 1'b1, 3'd6);
        expect_out("R10 code 6", 1'b0, 24'h0, 6'h0);
        apply({16'h0, enc2(4'd4, 4'd5)}, 1'b1, 3'd7);
        expect_out("R10 code 7", 1'b0, 24'h0, 6'h0);
    endtask

    task automatic t_short_ignore_r12;
        apply({16'hFFFF, enc3(4'd9, 4'd2, 4'd5)}, 1'b1, 3'd1);
        expect_out("R12 triple upper ones long", 1'b1, pack6(4'd9, 4'd2, 4'd5, 0, 0, 0), 6'h0);
        apply({16'h5A3C, enc2(4'd10, 4'd6)}, 1'b1, 3'd0);
        expect_out("R12 pair upper junk", 1'b1, pack6(4'd10, 4'd6, 0, 0, 0, 0), 6'h0);
        apply({16'h9F01, enc2(4'd0, 4'd10)}, 1'b1, 3'd3);
        expect_out("R12 bitpos upper junk", 1'b1, pack6(4'd0, 0, 0, 0, 0, 0), 6'd24);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset_r1();
        t_triple_r2();
        t_triple_bad_r3();
        t_pair_r4();
        t_pair_bad_r5();
        t_reg_imm_r6();
        t_bitpos_r7();
        t_quad_r8();
        t_hex_r9();
        t_forms_r10();
        t_short_ignore_r12();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule